// File: doc/BRIEF.md
# Serial-In Latched-Output Shift Register

The block takes a serial bit stream into a shift stage on one clock. On a second, independent clock it copies the whole shift stage into a storage stage. The storage stage drives a parallel output word that can be switched off as a group. The output enable does not gate the serial cascade output, which always carries the highest shift stage. Several copies can therefore be chained into a longer register: the cascade output of one copy feeds the serial input of the next.

An active-low asynchronous clear empties the shift stage at once and overrides the shift clock. It leaves the storage stage untouched, so the parallel outputs keep showing the last transferred word while a new one is loaded. The tri-state outputs are modelled as a data bus plus a per-bit drive-enable bus, which keeps the block synthesizable; pad cells outside the block do the actual high-impedance drive.

Top module: `srl_latched_top`

## Requirements
- R1: On each rising edge of the shift clock with the clear inactive, stage 0 takes the serial input and every stage k>0 takes the previous value of stage k-1.
- R2: The cascade output always equals the highest-index shift stage, whatever the output enable is.
- R3: Driving the clear low sets every shift stage to 0 at once; while it stays low, shift clock edges change nothing.
- R4: The clear never changes the storage stage or the parallel data output.
- R5: On each rising edge of the storage clock, the storage stage takes the shift stage contents as they were just before the edge; between those edges it holds its value.
- R6: With the output enable high, every bit of the drive-enable bus is 0 (undriven). With it low, every bit is 1. The data bus carries the storage stage in both cases.
- R7: With both clocks driven from one source, the storage stage after each edge equals the shift stage as it was before that edge, one edge behind.
- R8: When two copies are chained, cascade output into serial input, they act as one register of twice the width. The first serial bit shifted in ends up in the top stage of the second copy.
- R9: The width is a parameter (default 8). Bit 0 is the first stage and the cascade output is taken from the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift stage clock, rising edge |
| store_clk_i | input | 1 | Storage stage clock, rising edge |
| rst_ni | input | 1 | Asynchronous clear of the shift stage, active low |
| ser_i | input | 1 | Serial data into stage 0 |
| oe_ni | input | 1 | Parallel output enable, active low |
| cascade_o | output | 1 | Last shift stage, for chaining |
| out_data_o | output | WIDTH | Storage stage contents |
| out_en_o | output | WIDTH | Per-bit drive enable, 1 = driven |

## Verification
A wrong shift stage shows up on the cascade output at once when its top bit is wrong. A wrong lower bit needs up to WIDTH further shift edges to reach the cascade output, or one storage edge to appear on the parallel bus. A storage stage that loads at the wrong time, or is hit by the clear, shows on the data bus in the very cycle it happens. The reference model tracks the full chained register and both storage words edge by edge, so any such divergence is caught at the first sample after it occurs.

// File: rtl/srl_pkg.sv
`timescale 1ns/1ps
package srl_pkg;
  parameter int unsigned SRL_WIDTH_DEF = 8;
  typedef enum logic {DRIVE_OFF = 1'b0, DRIVE_ON = 1'b1} drive_e;
endpackage

// File: rtl/srl_shift_stage.sv
`timescale 1ns/1ps
module srl_shift_stage #(
  parameter int unsigned WIDTH = srl_pkg::SRL_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o,
  output logic             cascade_o
);
  localparam int unsigned TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= ser_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= g_bit[i-1].bit_q;
      end
    end
    assign stage_o[i] = bit_q;
  end

  assign cascade_o = stage_o[TOP];

  // set at the first shift edge after a clear, dropped by any clear
  logic clean_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clean_q <= 1'b0;
    else         clean_q <= 1'b1;
  end

  assert_shift_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_q |-> stage_o == {$past(stage_o[TOP-1:0]), $past(ser_i)});

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clean_q |-> stage_o == '0);
endmodule

// File: rtl/srl_hold_stage.sv
`timescale 1ns/1ps
module srl_hold_stage #(
  parameter int unsigned WIDTH = srl_pkg::SRL_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // the clear deliberately does not reach this register
  always_ff @(posedge clk_i) q_o <= d_i;

  logic primed_q = 1'b0;
  always_ff @(posedge clk_i) primed_q <= 1'b1;

  assert_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> q_o == $past(d_i));
endmodule

// File: rtl/srl_out_drive.sv
`timescale 1ns/1ps
module srl_out_drive
  import srl_pkg::*;
#(
  parameter int unsigned WIDTH = SRL_WIDTH_DEF
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] en_o
);
  drive_e drive;
  assign drive  = oe_ni ? DRIVE_OFF : DRIVE_ON;
  assign data_o = data_i;
  assign en_o   = {WIDTH{drive == DRIVE_ON}};
endmodule

// File: rtl/srl_latched_top.sv
`timescale 1ns/1ps
module srl_latched_top #(
  parameter int unsigned WIDTH = srl_pkg::SRL_WIDTH_DEF
) (
  input  logic             shift_clk_i,
  input  logic             store_clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             oe_ni,
  output logic             cascade_o,
  output logic [WIDTH-1:0] out_data_o,
  output logic [WIDTH-1:0] out_en_o
);
  logic [WIDTH-1:0] shift_w;
  logic [WIDTH-1:0] hold_w;

  srl_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk_i    (shift_clk_i),
    .rst_ni   (rst_ni),
    .ser_i    (ser_i),
    .stage_o  (shift_w),
    .cascade_o(cascade_o)
  );

  srl_hold_stage #(.WIDTH(WIDTH)) u_hold (
    .clk_i (store_clk_i),
    .rst_ni(rst_ni),
    .d_i   (shift_w),
    .q_o   (hold_w)
  );

  srl_out_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_ni (oe_ni),
    .data_i(hold_w),
    .data_o(out_data_o),
    .en_o  (out_en_o)
  );

  assert_drive_R6: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    ($countones(out_en_o) == 0) || ($countones(out_en_o) == WIDTH));

  assert_off_R6: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    oe_ni |-> out_en_o == '0);

  // the clear must leave the parallel word alone between storage edges
  assert_keep_R4: assert property (@(posedge shift_clk_i) disable iff (1'b0)
    (!rst_ni && $stable(store_clk_i) && !store_clk_i) |-> $stable(out_data_o));
endmodule

// File: tb/sim_srl_latched_top.sv
`timescale 1ns/1ps
module sim_srl_latched_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, oe_n = 1'b1, tie = 1'b0;
  logic sh_en = 1'b0, st_en = 1'b0, ser_b = 1'b0;
  logic armed = 1'b0, done = 1'b0;
  int   n_vec = 0, n_bad = 0;

  logic sh_clk, st_clk;
  assign sh_clk = tie ? clk : (clk & sh_en);
  assign st_clk = tie ? clk : (clk & st_en);

  logic         casc0, casc1;
  logic [W-1:0] d0, d1, e0, e1;

  srl_latched_top #(.WIDTH(W)) u0 (
    .shift_clk_i(sh_clk), .store_clk_i(st_clk), .rst_ni(rst_n), .ser_i(ser_b),
    .oe_ni(oe_n), .cascade_o(casc0), .out_data_o(d0), .out_en_o(e0));
  srl_latched_top #(.WIDTH(W)) u1 (
    .shift_clk_i(sh_clk), .store_clk_i(st_clk), .rst_ni(rst_n), .ser_i(casc0),
    .oe_ni(oe_n), .cascade_o(casc1), .out_data_o(d1), .out_en_o(e1));

  // reference: chain of 2W bits, bit k = stage k counted from u0 stage 0
  logic [2*W-1:0] m_sr = '0;
  logic [W-1:0]   m_st0 = '0, m_st1 = '0;

  always @(posedge clk) begin
    if (tie || st_en) begin
      m_st0 = m_sr[W-1:0];
      m_st1 = m_sr[2*W-1:W];
    end
    if (rst_n && (tie || sh_en)) m_sr = {m_sr[2*W-2:0], ser_b};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2", 32'(casc1), 32'(m_sr[2*W-1]));
    chk("R8", 32'(casc0), 32'(m_sr[W-1]));
    chk("R6", 32'(e0), oe_n ? 32'h0 : 32'hFF);
    chk("R6", 32'(e1), oe_n ? 32'h0 : 32'hFF);
    if (armed) begin
      chk("R5", 32'(d0), 32'(m_st0));
      chk("R5", 32'(d1), 32'(m_st1));
    end
  end

  task automatic step(input logic sh, input logic st, input logic s);
    @(negedge clk); #1;
    sh_en = sh; st_en = st; ser_b = s;
  endtask

  localparam logic [15:0] PAT = 16'hC3A5;

  initial begin
    repeat (3) @(negedge clk);
    chk("R3", 32'(casc1), 32'h0);
    chk("R6", 32'(e0), 32'h0);
    #1 rst_n = 1'b1;
    step(0, 1, 0);
    step(0, 0, 0);
    armed = 1'b1;
    chk("R9", 32'(d0), 32'h0);
    oe_n = 1'b0;

    // R1: single one into stage 0
    step(1, 0, 1); step(0, 1, 0); step(0, 0, 0);
    chk("R1", 32'(d0), 32'h01);

    // R8: 16 bits through the chain, first bit lands in u1 top stage
    for (int i = 15; i >= 0; i--) step(1, 0, PAT[i]);
    step(0, 1, 0); step(0, 0, 0);
    chk("R8", 32'(d1), 32'(PAT[15:8]));
    chk("R8", 32'(d0), 32'(PAT[7:0]));

    // R2: cascade keeps moving with outputs disabled
    oe_n = 1'b1;
    step(1, 0, 1); step(0, 0, 0);
    chk("R2", 32'(casc1), 32'(PAT[14]));
    chk("R6", 32'(e1), 32'h0);
    step(1, 0, 0); step(0, 0, 0);
    chk("R2", 32'(casc1), 32'(PAT[13]));
    chk("R2", 32'(d1), 32'(PAT[15:8]));

    // R3/R4: clear during active shifting
    oe_n = 1'b0;
    step(1, 0, 1);
    @(negedge clk); #1;
    rst_n = 1'b0; m_sr = '0;
    repeat (2) @(negedge clk);
    chk("R3", 32'(casc0), 32'h0);
    chk("R3", 32'(casc1), 32'h0);
    chk("R4", 32'(d0), 32'(PAT[7:0]));
    chk("R4", 32'(d1), 32'(PAT[15:8]));
    #1 sh_en = 1'b0; rst_n = 1'b1;
    step(0, 1, 0); step(0, 0, 0);
    chk("R3", 32'(d0), 32'h0);
    chk("R3", 32'(d1), 32'h0);

    // R5: shift without a storage edge, outputs hold
    for (int i = 0; i < W; i++) step(1, 0, 1);
    step(0, 0, 0);
    chk("R5", 32'(d0), 32'h0);
    step(0, 1, 0); step(0, 0, 0);
    chk("R5", 32'(d0), 32'hFF);

    // R7: tied clocks, storage one edge behind
    @(negedge clk); #1;
    tie = 1'b1; ser_b = 1'b0;
    @(negedge clk);
    chk("R7", 32'(d0), 32'hFF);
    @(negedge clk);
    chk("R7", 32'(d0), 32'hFE);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      ser_b = 1'($urandom);
    end
    @(negedge clk); #1;
    tie = 1'b0;

    // mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      step(1'($urandom), 1'($urandom), 1'($urandom));
      if ((i % 37) == 0) oe_n = ~oe_n;
    end
    step(0, 0, 0);
    step(0, 0, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule